// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider Pair

This block is one divider channel made of two stages in series. Each stage produces an output waveform whose high time and low time are each set by their own 4-bit count. The first stage runs from the reference clock. The second stage counts rising edges of the first stage's output. Each stage also has:
- a phase offset that delays its first transition;
- a start-level select;
- a bypass that hands its input straight to its output and idles its counters.

The whole design runs on one reference clock. The reference clock is represented as a level of 1 with an input tick on every cycle. Each stage output is a level that changes only on the reference clock, so every waveform is a clock-enable style signal in that domain.

A shared synchronization input holds both stages at their start levels while it is high. Releasing it starts the waveforms. A no-sync control makes the channel ignore that input; while no-sync is set, both outputs show a static forced level. Configuration is copied into shadow registers while sync is held, so edits made while the channel runs change nothing until the next sync release. Both channel outputs are registered.

Top module: `cdiv_channel`

## Requirements
- R1: With a stage active, its output stays high for exactly (high count + 1) of that stage's input ticks in every high phase.
- R2: With a stage active, its output stays low for exactly (low count + 1) of that stage's input ticks in every low phase.
- R3: The second stage's input tick is each rising edge of the first stage's output. Each of its phases therefore lasts a whole number of first-stage periods, where one period is (high + 1) + (low + 1) reference cycles.
- R4: While sync is high and no-sync is 0, each stage output sits at its start bit (1 = high, 0 = low). After release, the first run of a stage is at that level.
- R5: After sync release, a stage keeps its start level for an extra (phase offset) input ticks before its normal count begins. Its first run therefore lasts offset + count + 1 ticks.
- R6: A bypass bit of 1 makes that stage's output follow its input. A bypassed first stage gives a constant high output and gives the second stage one tick per reference cycle. A bypassed second stage copies the first stage's output.
- R7: With no-sync at 1, the sync input has no effect on either output.
- R8: With no-sync at 1, both outputs equal the force bit (1 = high, 0 = low). With no-sync at 0, the force bit has no effect.
- R9: Configuration inputs are captured only while sync is obeyed and high, or during reset. Changes made after release leave the running waveforms unchanged.
- R10: Outputs are registered: counting cycles from the first reference cycle after sync falls, a stage's first run at its start level lasts exactly the tick counts above. During synchronous reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Shared synchronization hold, high holds stages at start level |
| nosync_i | input | 1 | 1 = ignore sync_i and show the forced level |
| force_hi_i | input | 1 | Forced output level used while nosync_i is 1 |
| a_hi_i | input | 4 | First stage high count (N gives N+1 ticks) |
| a_lo_i | input | 4 | First stage low count (N gives N+1 ticks) |
| a_phase_i | input | 4 | First stage phase offset in input ticks |
| a_start_i | input | 1 | First stage start level |
| a_bypass_i | input | 1 | First stage bypass |
| b_hi_i | input | 4 | Second stage high count |
| b_lo_i | input | 4 | Second stage low count |
| b_phase_i | input | 4 | Second stage phase offset in input ticks |
| b_start_i | input | 1 | Second stage start level |
| b_bypass_i | input | 1 | Second stage bypass |
| a_out_o | output | 1 | Registered first stage output |
| b_out_o | output | 1 | Registered second stage (channel) output |

## Verification
The in-line assertions check these properties on every cycle:
- each phase counter stays within its programmed limit;
- a stage output moves only on an input tick and never during its offset wait;
- a held stage shows its start level;
- shadow configuration changes only while sync is obeyed;
- the forced level appears whenever no-sync is set.

The exact lengths of high, low, first and offset runs can only be shown by the bench's sweeps, as can the cascade arithmetic and the immunity to mid-run configuration edits. The bench compares every sample of each waveform window against a closed-form expected level.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  parameter int CNT_W  = 4;
  parameter int NUM_ST = 2;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] ph;
    logic             start;
    logic             bypass;
  } stage_cfg_t;
endpackage

// File: rtl/cdiv_cfg_hold.sv
module cdiv_cfg_hold
  import cdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  stage_cfg_t cfg_i,
  output stage_cfg_t cfg_o
);
  always_ff @(posedge clk) begin
    if (rst || load) cfg_o <= cfg_i;
  end

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_o)); // R9
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage
  import cdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       in_tick,
  input  logic       in_level,
  input  stage_cfg_t cfg_i,
  output logic       out_tick,
  output logic       out_level
);
  stage_cfg_t       cfg_q;
  logic [CNT_W-1:0] wait_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             lvl_q;
  logic             tick_q;
  logic             in_wait;
  logic             flip;
  logic             start_in;

  cdiv_cfg_hold u_shadow (
    .clk   (clk),
    .rst   (rst),
    .load  (hold),
    .cfg_i (cfg_i),
    .cfg_o (cfg_q)
  );

  assign start_in = cfg_i.start;
  assign lim      = lvl_q ? cfg_q.hi : cfg_q.lo;
  assign in_wait  = (wait_q != '0);
  assign flip     = in_tick && !in_wait && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      wait_q <= cfg_i.ph;
      cnt_q  <= '0;
      lvl_q  <= cfg_i.start;
      tick_q <= 1'b0;
    end else if (cfg_q.bypass) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= flip && !lvl_q;
      if (in_tick) begin
        if (in_wait) begin
          wait_q <= wait_q - 1'b1;
        end else if (cnt_q == lim) begin
          lvl_q <= ~lvl_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign out_level = cfg_q.bypass ? in_level : lvl_q;
  assign out_tick  = cfg_q.bypass ? in_tick  : tick_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim); // R1
  AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
    hold |=> (lvl_q == $past(start_in))); // R4
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!hold && !in_tick) |=> $stable(lvl_q)); // R3
  AST_OFFSET_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!hold && in_wait) |=> $stable(lvl_q)); // R5
endmodule

// File: rtl/cdiv_out_reg.sv
module cdiv_out_reg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         nosync,
  input  logic         force_hi,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (nosync) q_o <= {N{force_hi}};
    else             q_o <= lvl_i;
  end

  AST_FORCED_LEVEL: assert property (@(posedge clk) disable iff (rst)
    nosync |=> (q_o == {N{$past(force_hi)}})); // R8
endmodule

// File: rtl/cdiv_channel.sv
module cdiv_channel
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic             nosync_i,
  input  logic             force_hi_i,
  input  logic [CNT_W-1:0] a_hi_i,
  input  logic [CNT_W-1:0] a_lo_i,
  input  logic [CNT_W-1:0] a_phase_i,
  input  logic             a_start_i,
  input  logic             a_bypass_i,
  input  logic [CNT_W-1:0] b_hi_i,
  input  logic [CNT_W-1:0] b_lo_i,
  input  logic [CNT_W-1:0] b_phase_i,
  input  logic             b_start_i,
  input  logic             b_bypass_i,
  output logic             a_out_o,
  output logic             b_out_o
);
  stage_cfg_t        cfg [NUM_ST];
  logic [NUM_ST-1:0] tick;
  logic [NUM_ST-1:0] lvl;
  logic [NUM_ST-1:0] q;
  logic              hold;

  assign hold = sync_i && !nosync_i;

  assign cfg[0] = '{hi: a_hi_i, lo: a_lo_i, ph: a_phase_i,
                    start: a_start_i, bypass: a_bypass_i};
  assign cfg[1] = '{hi: b_hi_i, lo: b_lo_i, ph: b_phase_i,
                    start: b_start_i, bypass: b_bypass_i};

  for (genvar g = 0; g < NUM_ST; g++) begin : g_stage
    logic src_tick;
    logic src_level;
    if (g == 0) begin : g_head
      assign src_tick  = 1'b1;
      assign src_level = 1'b1;
    end else begin : g_tail
      assign src_tick  = tick[g-1];
      assign src_level = lvl[g-1];
    end
    cdiv_stage u_stage (
      .clk       (clk),
      .rst       (rst),
      .hold      (hold),
      .in_tick   (src_tick),
      .in_level  (src_level),
      .cfg_i     (cfg[g]),
      .out_tick  (tick[g]),
      .out_level (lvl[g])
    );
  end

  cdiv_out_reg #(.N(NUM_ST)) u_out (
    .clk      (clk),
    .rst      (rst),
    .nosync   (nosync_i),
    .force_hi (force_hi_i),
    .lvl_i    (lvl),
    .q_o      (q)
  );

  assign a_out_o = q[0];
  assign b_out_o = q[NUM_ST-1];

  AST_NOSYNC_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (nosync_i && $past(nosync_i)) |-> (a_out_o == b_out_o)); // R7
endmodule

// File: tb/tb_cdiv_channel.sv
module tb_cdiv_channel;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, sync_i, nosync_i, force_hi_i;
  logic [3:0] a_hi_i, a_lo_i, a_phase_i, b_hi_i, b_lo_i, b_phase_i;
  logic a_start_i, a_bypass_i, b_start_i, b_bypass_i;
  logic a_out_o, b_out_o;

  int n_vec = 0;
  int n_bad = 0;

  cdiv_channel dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .nosync_i(nosync_i),
    .force_hi_i(force_hi_i),
    .a_hi_i(a_hi_i), .a_lo_i(a_lo_i), .a_phase_i(a_phase_i),
    .a_start_i(a_start_i), .a_bypass_i(a_bypass_i),
    .b_hi_i(b_hi_i), .b_lo_i(b_lo_i), .b_phase_i(b_phase_i),
    .b_start_i(b_start_i), .b_bypass_i(b_bypass_i),
    .a_out_o(a_out_o), .b_out_o(b_out_o)
  );

  function automatic logic exp_lvl(int idx, int first, int opp, int same, logic s);
    int m;
    if (idx < first) return s;
    m = (idx - first) % (opp + same);
    return (m < opp) ? ~s : s;
  endfunction

  task automatic check(string tag, logic act, logic exp, int idx);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s sample %0d: actual %b expected %b", tag, idx, act, exp);
    end
  endtask

  task automatic run_case(int h1, int l1, int p1, int s1, int b1,
                          int h2, int l2, int p2, int s2, int b2,
                          int frc, int scramble, string tag);
    int f1, o1, m1, t1, r1, f2, o2, m2, k, w;
    logic e1, e2, bad1, bad2;
    int at1, at2;
    logic v1, v2, x1, x2;
    @(negedge clk);
    a_hi_i = 4'(h1); a_lo_i = 4'(l1); a_phase_i = 4'(p1);
    a_start_i = 1'(s1); a_bypass_i = 1'(b1);
    b_hi_i = 4'(h2); b_lo_i = 4'(l2); b_phase_i = 4'(p2);
    b_start_i = 1'(s2); b_bypass_i = 1'(b2);
    force_hi_i = 1'(frc); nosync_i = 1'b0; sync_i = 1'b1;
    repeat (3) @(negedge clk);
    // R4: held outputs sit at the start levels (bypassed first stage reads high)
    e1 = b1 ? 1'b1 : 1'(s1);
    e2 = b2 ? e1 : 1'(s2);
    check({tag, " R4 hold a"}, a_out_o, e1, -1);
    check({tag, " R4 hold b"}, b_out_o, e2, -1);
    // expected first-stage waveform
    f1 = p1 + (s1 != 0 ? h1 : l1) + 1;
    o1 = (s1 != 0 ? l1 : h1) + 1;
    m1 = (s1 != 0 ? h1 : l1) + 1;
    t1 = b1 ? 1 : (h1 + l1 + 2);
    r1 = b1 ? 0 : (s1 != 0 ? f1 + o1 : f1);
    // expected second-stage waveform, counted in first-stage rising edges
    k  = p2 + (s2 != 0 ? h2 : l2) + 1;
    f2 = r1 + (k - 1) * t1 + 1;
    o2 = ((s2 != 0 ? l2 : h2) + 1) * t1;
    m2 = ((s2 != 0 ? h2 : l2) + 1) * t1;
    w  = b2 ? (f1 + 2 * t1 + 2) : (f2 + 2 * (o2 + m2) + 2);
    if (w < f1 + 2 * t1 + 2) w = f1 + 2 * t1 + 2;
    sync_i = 1'b0;
    bad1 = 1'b0; bad2 = 1'b0; at1 = 0; at2 = 0; v1 = 0; v2 = 0; x1 = 0; x2 = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (scramble != 0 && i == 0) begin
        // R9 R8: edits after release must not disturb the waveforms
        a_hi_i = ~a_hi_i; a_lo_i = a_lo_i + 4'd5; a_phase_i = ~a_phase_i;
        a_start_i = ~a_start_i; a_bypass_i = ~a_bypass_i;
        b_hi_i = b_hi_i + 4'd3; b_lo_i = ~b_lo_i; b_phase_i = b_phase_i + 4'd7;
        b_start_i = ~b_start_i; b_bypass_i = ~b_bypass_i;
        force_hi_i = ~force_hi_i;
      end
      e1 = b1 ? 1'b1 : exp_lvl(i, f1, o1, m1, 1'(s1));
      e2 = b2 ? e1   : exp_lvl(i, f2, o2, m2, 1'(s2));
      if (!bad1 && a_out_o !== e1) begin bad1 = 1; at1 = i; v1 = a_out_o; x1 = e1; end
      if (!bad2 && b_out_o !== e2) begin bad2 = 1; at2 = i; v2 = b_out_o; x2 = e2; end
    end
    check({tag, " a waveform"}, bad1 ? v1 : 1'b0, bad1 ? x1 : 1'b0, at1);
    check({tag, " b waveform"}, bad2 ? v2 : 1'b0, bad2 ? x2 : 1'b0, at2);
  endtask

  task automatic force_case(logic lvl);
    @(negedge clk);
    nosync_i = 1'b1; force_hi_i = lvl; sync_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sync_i = (i % 7) < 3;   // R7: sync activity while ignored
      if (i % 10 == 9) begin
        check("R8 R7 forced a", a_out_o, lvl, i);
        check("R8 R7 forced b", b_out_o, lvl, i);
      end
    end
    @(negedge clk);
    nosync_i = 1'b0; sync_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; sync_i = 1'b0; nosync_i = 1'b0; force_hi_i = 1'b1;
    a_hi_i = 4'd2; a_lo_i = 4'd1; a_phase_i = 4'd0; a_start_i = 1'b1; a_bypass_i = 1'b0;
    b_hi_i = 4'd1; b_lo_i = 4'd1; b_phase_i = 4'd0; b_start_i = 1'b1; b_bypass_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset a", a_out_o, 1'b0, 0);
    check("R10 reset b", b_out_o, 1'b0, 0);
    rst = 1'b0;

    // R1 R2 R10: every first-stage high/low pair, second stage bypassed
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++)
        run_case(h, l, 0, (h ^ l) & 1, 0, 0, 0, 0, 0, 1, h & 1, 0, "R1 R2");

    // R6 R1 R2: every second-stage pair with the first stage bypassed
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++)
        run_case(0, 0, 0, 0, 1, h, l, 0, (h + l) & 1, 0, l & 1, 0, "R6 R1 R2");

    // R5 R4: every offset with both start levels, on each stage
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < 2; s++) begin
        run_case(3, 5, p, s, 0, 0, 0, 0, 0, 1, 0, 0, "R5 R4 first");
        run_case(0, 0, 0, 0, 1, 4, 2, p, s, 0, 1, 0, "R5 R4 second");
      end

    // R3: cascaded stages
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++)
        for (int s = 0; s < 4; s++)
          run_case(1, 0, 1, s & 1, 0, h, l, 2 * (s >> 1), s >> 1, 0, 0, 0, "R3 cascade");
    run_case(2, 3, 0, 1, 0, 5, 1, 1, 0, 0, 1, 0, "R3 cascade wide");

    // R6: both stages bypassed
    run_case(7, 7, 7, 0, 1, 7, 7, 7, 0, 1, 0, 0, "R6 both bypassed");

    // R9: configuration edits during the run
    run_case(2, 4, 1, 0, 0, 1, 2, 1, 1, 0, 0, 1, "R9 R8 edit");
    run_case(5, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 1, "R9 R8 edit");
    run_case(0, 0, 0, 0, 1, 3, 6, 2, 0, 0, 0, 1, "R9 R8 edit");

    // R7 R8: ignore sync, forced levels
    force_case(1'b1);
    force_case(1'b0);
    run_case(1, 2, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0, "R7 resume");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule